// File: doc/BRIEF.md
# SDRAM Row Boundary Decoder

This block maps a physical address onto one of four SDRAM chip-select rows. Each row is described only by its upper limit. The limit is an 8-bit boundary value counted in 16 MB units. The limits are cumulative: a row starts where the populated rows below it end, and row 0 starts at address zero. A row that adds no address space over the rows below it holds no memory and is skipped. This covers a limit equal to the previous one and a limit lower than the previous one.

Software programs the four boundary values and one mode byte through a narrow write port, one value per write. The mode byte holds two global settings, ECC enable and registered DIMM type. Both apply to every row and are presented directly as outputs.

Each valid address is decoded in a single registered stage. One cycle later the block presents a one-hot row select, a hit flag and the base address of the chosen row.

Top module: `sdram_row_decoder`

## Requirements
- R1: While reset (active low) is sampled low, all boundary values and both mode bits clear. One cycle later `sel_valid`, `row_sel`, `row_hit`, `row_base`, `ecc_on` and `dimm_registered` are all zero. With all boundaries at zero, every address misses.
- R2: A write at offset 0, 1, 2 or 3 loads the boundary value of row 0, 1, 2 or 3. A write at offset 4 loads the mode byte. A write at offsets 5 to 7 changes no boundary and no mode bit.
- R3: A boundary value v sets an upper limit of v multiplied by 2^24, and that limit is exclusive. Addresses from 0 up to row 0's limit minus one select row 0, with base 0. `row_base` always has its low 24 bits at zero.
- R4: The base of row n is the largest limit among rows 0 to n-1 (zero for row 0). An address in row n reports that base on `row_base`.
- R5: A row whose limit equals the base below it is empty and is never selected. Addresses past it fall into the next row that holds memory.
- R6: An address at or above the highest programmed limit gives `row_sel` = 0, `row_hit` = 0 and `row_base` = 0.
- R7: A row whose limit is lower than the largest limit below it is treated as empty. The rows above it take their base from that largest limit.
- R8: A decode started with `addr_valid` high at one rising edge is shown at the outputs after that edge, with `sel_valid` high. A cycle with `addr_valid` low gives `sel_valid` = 0, `row_sel` = 0, `row_hit` = 0 and `row_base` = 0 after its edge.
- R9: `row_sel` has at most one bit set, bit n meaning row n. `row_hit` is high exactly when one bit is set. If more than one row matches, the lowest-numbered row wins.
- R10: Mode byte bit 0 drives `ecc_on` and bit 1 drives `dimm_registered`, for all rows, from the cycle after the write. The mode bits have no effect on the row decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Write strobe for the boundary and mode registers |
| cfg_wr_off | input | 3 | Register offset: 0-3 row boundaries, 4 mode byte |
| cfg_wr_data | input | 8 | Write data |
| addr_valid | input | 1 | Address is valid this cycle |
| addr | input | 32 | Physical address to decode |
| sel_valid | output | 1 | Decode result is valid |
| row_sel | output | 4 | One-hot selected row |
| row_hit | output | 1 | Address falls in a populated row |
| row_base | output | 32 | Base address of the selected row |
| ecc_on | output | 1 | Global ECC enable |
| dimm_registered | output | 1 | Global registered DIMM type |

## Verification
The hardest situation to reach from the ports is a boundary set programmed out of order. In that case a row's own limit lies below the running maximum, and the row must collapse to empty. The rows above it must then take their base from an earlier row, not from their direct neighbour. The stimulus programs limits 0x40, 0x20, 0x60, 0x50. It then probes addresses on both sides of each boundary. This shows that rows 1 and 3 are never chosen, that row 2 is based at 0x40000000, and that the window past 0x60 misses. A separate pattern repeats a limit to show that an equal boundary also collapses.

// File: rtl/row_dec_pkg.sv
// Package: shared types for the SDRAM row boundary decoder.
// Holds the global mode-bit layout used by the register file and the top.
package row_dec_pkg;

    // Bit positions of the mode byte.
    localparam int MODE_ECC_BIT = 0;
    localparam int MODE_REG_BIT = 1;

    // Global memory mode settings shared by all rows.
    typedef struct packed {
        logic dimm_reg;
        logic ecc_en;
    } mode_t;

endpackage

// File: rtl/row_limit_regs.sv
// Module: row_limit_regs
// Holds one boundary value per row plus the global mode byte, loaded
// through a single-word write port. Offsets 0..NUM_ROWS-1 address the
// rows, offset NUM_ROWS the mode byte; higher offsets are ignored.
// Assumes DATA_W >= 2 so that both mode bits fit in one write.
module row_limit_regs
    import row_dec_pkg::*;
#(
    parameter int NUM_ROWS = 4,
    parameter int DATA_W   = 8,
    parameter int OFF_W    = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [OFF_W-1:0]                  wr_off,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [NUM_ROWS-1:0][DATA_W-1:0]   limits,
    output mode_t                             mode
);

    localparam logic [OFF_W-1:0] MODE_OFF = OFF_W'(NUM_ROWS);

    logic wr_data_unused;
    assign wr_data_unused = ^wr_data[DATA_W-1:2];

    generate
        for (genvar n = 0; n < NUM_ROWS; n++) begin : g_row
            // Load this row's boundary when its offset is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    limits[n] <= '0;
                else if (wr_en && wr_off == OFF_W'(n))
                    limits[n] <= wr_data;
            end

            // Written value appears in the addressed row (R2).
            assert_row_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_off == OFF_W'(n)) |=> (limits[n] == $past(wr_data)));
        end
    endgenerate

    // Load the global mode bits when the mode offset is written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= '0;
        else if (wr_en && wr_off == MODE_OFF) begin
            mode.ecc_en   <= wr_data[MODE_ECC_BIT];
            mode.dimm_reg <= wr_data[MODE_REG_BIT];
        end
    end

    // Writes to unmapped offsets leave every register unchanged (R2).
    assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off > MODE_OFF) |=> ($stable(limits) && $stable(mode)));

endmodule

// File: rtl/row_range_cmp.sv
// Module: row_range_cmp
// Computes each row's base as the running maximum of the limits below
// it, and flags the rows whose [base, limit) window contains the
// address. A row whose limit does not exceed its base is empty.
// Compares only the upper address bits: limits are whole units.
module row_range_cmp #(
    parameter int NUM_ROWS = 4,
    parameter int LIMIT_W  = 8
) (
    input  logic [LIMIT_W-1:0]                addr_top,
    input  logic [NUM_ROWS-1:0][LIMIT_W-1:0]  limits,
    output logic [NUM_ROWS-1:0]               in_row,
    output logic [NUM_ROWS-1:0][LIMIT_W-1:0]  bases
);

    logic [NUM_ROWS:0][LIMIT_W-1:0] running;

    assign running[0] = '0;

    generate
        for (genvar n = 0; n < NUM_ROWS; n++) begin : g_cmp
            logic populated;
            // Base is the highest limit seen in the rows below.
            assign bases[n]      = running[n];
            // Carry the highest limit forward to the next row.
            assign running[n+1]  = (limits[n] > running[n]) ? limits[n] : running[n];
            // A row holds memory only when it extends past its base.
            assign populated     = limits[n] > running[n];
            // Address lies in the row's half-open window.
            assign in_row[n]     = populated && (addr_top >= running[n]) && (addr_top < limits[n]);
        end
    endgenerate

endmodule

// File: rtl/row_pick.sv
// Module: row_pick
// Chooses the lowest-numbered matching row, giving a one-hot select,
// a hit flag and the chosen row's base. Assumes nothing about how
// many rows match.
module row_pick #(
    parameter int NUM_ROWS = 4,
    parameter int LIMIT_W  = 8
) (
    input  logic [NUM_ROWS-1:0]               in_row,
    input  logic [NUM_ROWS-1:0][LIMIT_W-1:0]  bases,
    output logic [NUM_ROWS-1:0]               sel,
    output logic                              hit,
    output logic [LIMIT_W-1:0]                base_sel
);

    // Priority pick: the first matching row from row 0 upward wins.
    always_comb begin
        sel = '0;
        for (int n = 0; n < NUM_ROWS; n++) begin
            if (in_row[n] && sel == '0)
                sel[n] = 1'b1;
        end
    end

    // Hit whenever any row was chosen.
    assign hit = |in_row;

    // Select the chosen row's base; zero on a miss.
    always_comb begin
        base_sel = '0;
        for (int n = 0; n < NUM_ROWS; n++) begin
            if (sel[n])
                base_sel = base_sel | bases[n];
        end
    end

endmodule

// File: rtl/sdram_row_decoder.sv
// Module: sdram_row_decoder (top)
// Decodes a physical address onto one of NUM_ROWS SDRAM rows bounded
// by cumulative upper limits, with one register stage from address to
// result. Assumes LIMIT_SHIFT + LIMIT_W == ADDR_W, so each boundary
// value covers the full upper address field.
module sdram_row_decoder
    import row_dec_pkg::*;
#(
    parameter int NUM_ROWS    = 4,
    parameter int LIMIT_W     = 8,
    parameter int ADDR_W      = 32,
    parameter int LIMIT_SHIFT = 24,
    parameter int OFF_W       = $clog2(NUM_ROWS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr_en,
    input  logic [OFF_W-1:0]      cfg_wr_off,
    input  logic [LIMIT_W-1:0]    cfg_wr_data,
    input  logic                  addr_valid,
    input  logic [ADDR_W-1:0]     addr,
    output logic                  sel_valid,
    output logic [NUM_ROWS-1:0]   row_sel,
    output logic                  row_hit,
    output logic [ADDR_W-1:0]     row_base,
    output logic                  ecc_on,
    output logic                  dimm_registered
);

    generate
        if (LIMIT_SHIFT + LIMIT_W != ADDR_W) begin : g_bad_cfg
            $error("LIMIT_SHIFT + LIMIT_W must equal ADDR_W");
        end
    endgenerate

    logic [NUM_ROWS-1:0][LIMIT_W-1:0] limits;
    mode_t                            mode;
    logic [NUM_ROWS-1:0][LIMIT_W-1:0] bases;
    logic [NUM_ROWS-1:0]              in_row;
    logic [NUM_ROWS-1:0]              pick_sel;
    logic                             pick_hit;
    logic [LIMIT_W-1:0]               pick_base;
    logic [LIMIT_W-1:0]               addr_top;
    logic                             addr_low_unused;

    assign addr_top        = addr[ADDR_W-1 -: LIMIT_W];
    assign addr_low_unused = ^addr[LIMIT_SHIFT-1:0];

    row_limit_regs #(
        .NUM_ROWS (NUM_ROWS),
        .DATA_W   (LIMIT_W),
        .OFF_W    (OFF_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_off  (cfg_wr_off),
        .wr_data (cfg_wr_data),
        .limits  (limits),
        .mode    (mode)
    );

    row_range_cmp #(
        .NUM_ROWS (NUM_ROWS),
        .LIMIT_W  (LIMIT_W)
    ) cmp_i (
        .addr_top (addr_top),
        .limits   (limits),
        .in_row   (in_row),
        .bases    (bases)
    );

    row_pick #(
        .NUM_ROWS (NUM_ROWS),
        .LIMIT_W  (LIMIT_W)
    ) pick_i (
        .in_row   (in_row),
        .bases    (bases),
        .sel      (pick_sel),
        .hit      (pick_hit),
        .base_sel (pick_base)
    );

    // Register the decode result; clear it in idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !addr_valid) begin
            sel_valid <= 1'b0;
            row_sel   <= '0;
            row_hit   <= 1'b0;
            row_base  <= '0;
        end else begin
            sel_valid <= 1'b1;
            row_sel   <= pick_sel;
            row_hit   <= pick_hit;
            row_base  <= {pick_base, {LIMIT_SHIFT{1'b0}}};
        end
    end

    assign ecc_on          = mode.ecc_en;
    assign dimm_registered = mode.dimm_reg;

    // Reset leaves outputs and mode bits clear (R1).
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!sel_valid && row_sel == '0 && !ecc_on && !dimm_registered));

    // Valid address yields a valid result one cycle later (R8).
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> sel_valid);

    // Idle cycle clears the result (R8).
    assert_idle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> (!sel_valid && !row_hit && row_sel == '0));

    // Select is one-hot and agrees with the hit flag (R9).
    assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel) && (row_hit == (row_sel != '0)));

    // Windows of populated rows never overlap (R7).
    assert_rows_disjoint_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_row));

    // Chosen base never exceeds the decoded address (R4).
    assert_base_le_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        row_hit |-> (row_base <= $past(addr)));

    // Base is aligned to the boundary unit (R3).
    assert_base_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        row_base[LIMIT_SHIFT-1:0] == '0);

    // A miss reports a zero base (R6).
    assert_miss_base_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !row_hit |-> (row_base == '0));

endmodule

// File: tb/sdram_row_decoder_tb_top.sv
`timescale 1ns/1ps
// Directed bench for sdram_row_decoder: one task per scenario.
module sdram_row_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_off = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic        addr_valid = 1'b0;
    logic [31:0] addr = '0;
    logic        sel_valid;
    logic [3:0]  row_sel;
    logic        row_hit;
    logic [31:0] row_base;
    logic        ecc_on;
    logic        dimm_registered;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    sdram_row_decoder dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_wr_en       (cfg_wr_en),
        .cfg_wr_off      (cfg_wr_off),
        .cfg_wr_data     (cfg_wr_data),
        .addr_valid      (addr_valid),
        .addr            (addr),
        .sel_valid       (sel_valid),
        .row_sel         (row_sel),
        .row_hit         (row_hit),
        .row_base        (row_base),
        .ecc_on          (ecc_on),
        .dimm_registered (dimm_registered)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] off, input logic [7:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_off = off; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic set_limits(input logic [7:0] l0, l1, l2, l3);
        wr(3'd0, l0); wr(3'd1, l1); wr(3'd2, l2); wr(3'd3, l3);
    endtask

    // Decode one address and compare select, hit and base.
    task automatic probe(input string tag, input logic [31:0] a,
                         input logic [3:0] es, input logic [31:0] eb);
        @(negedge clk);
        addr = a; addr_valid = 1'b1;
        @(negedge clk);
        chk({tag, " valid"}, 32'(sel_valid), 32'd1);
        chk({tag, " sel"},   32'(row_sel),   32'(es));
        chk({tag, " hit"},   32'(row_hit),   32'(es != 4'd0));
        chk({tag, " base"},  row_base,       eb);
        addr_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 sel_valid", 32'(sel_valid), 0);
        chk("R1 row_sel", 32'(row_sel), 0);
        chk("R1 ecc_on", 32'(ecc_on), 0);
        chk("R1 dimm_registered", 32'(dimm_registered), 0);
        probe("R1 all-empty miss", 32'h0000_0000, 4'b0000, 32'h0);
    endtask

    task automatic t_basic();
        set_limits(8'h10, 8'h20, 8'h40, 8'h80);
        probe("R3 row0 bottom", 32'h0000_0000, 4'b0001, 32'h0);
        probe("R3 row0 top",    32'h0FFF_FFFF, 4'b0001, 32'h0);
        probe("R4 row1 bottom", 32'h1000_0000, 4'b0010, 32'h1000_0000);
        probe("R4 row2 top",    32'h3FFF_FFFF, 4'b0100, 32'h2000_0000);
        probe("R4 row3 top",    32'h7FFF_FFFF, 4'b1000, 32'h4000_0000);
        probe("R6 at top limit", 32'h8000_0000, 4'b0000, 32'h0);
        probe("R6 max address", 32'hFFFF_FFFF, 4'b0000, 32'h0);
    endtask

    task automatic t_empty();
        set_limits(8'h10, 8'h10, 8'h30, 8'h30);
        probe("R5 skip empty row1", 32'h1000_0000, 4'b0100, 32'h1000_0000);
        probe("R5 row0 still",      32'h0800_0000, 4'b0001, 32'h0);
        probe("R5 empty row3 miss", 32'h3000_0000, 4'b0000, 32'h0);
    endtask

    task automatic t_out_of_order();
        set_limits(8'h40, 8'h20, 8'h60, 8'h50);
        probe("R7 below lower limit stays row0", 32'h2000_0000, 4'b0001, 32'h0);
        probe("R7 row2 base from row0", 32'h4000_0000, 4'b0100, 32'h4000_0000);
        probe("R7 row3 window in row2", 32'h5800_0000, 4'b0100, 32'h4000_0000);
        probe("R7 past max miss", 32'h6000_0000, 4'b0000, 32'h0);
    endtask

    task automatic t_full_range();
        set_limits(8'h10, 8'h20, 8'h40, 8'hFF);
        probe("R3 just below 0xFF limit", 32'hFEFF_FFFF, 4'b1000, 32'h4000_0000);
        probe("R6 at 0xFF limit", 32'hFF00_0000, 4'b0000, 32'h0);
    endtask

    task automatic t_mode();
        wr(3'd4, 8'h01);
        chk("R10 ecc_on set", 32'(ecc_on), 1);
        chk("R10 dimm_registered clear", 32'(dimm_registered), 0);
        wr(3'd4, 8'h02);
        chk("R10 ecc_on clear", 32'(ecc_on), 0);
        chk("R10 dimm_registered set", 32'(dimm_registered), 1);
        probe("R10 decode unaffected", 32'h3000_0000, 4'b0100, 32'h2000_0000);
    endtask

    task automatic t_unmapped();
        wr(3'd5, 8'h00); wr(3'd6, 8'h00); wr(3'd7, 8'h01);
        chk("R2 mode kept ecc", 32'(ecc_on), 0);
        chk("R2 mode kept reg", 32'(dimm_registered), 1);
        probe("R2 limits kept row0", 32'h0000_0000, 4'b0001, 32'h0);
        probe("R2 limits kept row3", 32'hFEFF_FFFF, 4'b1000, 32'h4000_0000);
        wr(3'd2, 8'h30);
        probe("R2 row2 rewrite", 32'h3800_0000, 4'b1000, 32'h3000_0000);
    endtask

    task automatic t_latency();
        @(negedge clk);
        addr = 32'h0000_1000; addr_valid = 1'b1;
        #2 chk("R8 not before edge", 32'(sel_valid), 0);
        @(negedge clk);
        chk("R8 valid after one edge", 32'(sel_valid), 1);
        chk("R9 lowest row", 32'(row_sel), 32'b0001);
        addr_valid = 1'b0;
        @(negedge clk);
        chk("R8 idle clears valid", 32'(sel_valid), 0);
        chk("R8 idle clears sel", 32'(row_sel), 0);
        chk("R8 idle clears base", row_base, 0);
    endtask

    task automatic t_reset_midrun();
        do_reset();
        chk("R1 mode cleared", 32'(dimm_registered), 0);
        probe("R1 limits cleared", 32'h0000_0000, 4'b0000, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_empty();
        t_out_of_order();
        t_full_range();
        t_mode();
        t_unmapped();
        t_latency();
        t_reset_midrun();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule